// File: doc/BRIEF.md
# Serial Memory Slave Select and Pause Front-End

This block sits at the pin edge of a serial memory slave. It brings the chip-select, serial clock, pause (hold) and data-in pins into the system clock domain. It decides when the slave counts as selected. It tracks whether serial traffic is paused. It hands each qualified rising edge of the serial clock to a downstream shifter as a one-cycle strobe, together with the data bit sampled at that edge.

Selection is armed by an edge, not by a level. After power-on reset is released, a chip select that is already low is not enough: the slave waits until it sees chip select go from high to low. A pause is entered or left only while the serial clock is low. Dropping the selection during a pause produces a single-cycle clear pulse for the downstream command and bit-count state. A standby flag reports an idle slave, and it is held off while the write engine is busy.

Top module: `sel_hold_frontend`

## Requirements
- R1: When the system reset is released, `sel_o`, `held_o`, `shift_stb_o`, `state_clr_o` and `dout_en_o` are all 0.
- R2: While `por_i` is 1, any activity on the pins leaves `sel_o` at 0, leaves `standby_o` at 0 and produces no `shift_stb_o` pulse.
- R3: When `por_i` is released while `cs_n_i` is already low, `sel_o` stays 0. It becomes 1 only after `cs_n_i` has been seen going from 1 to 0.
- R4: After an arming fall, `sel_o` is 1 while `cs_n_i` is low and drops when `cs_n_i` goes high. `dout_en_o` is 1 exactly when the slave is selected and not paused.
- R5: Each rising edge of `sclk_i` while the slave is selected and not paused gives exactly one single-cycle `shift_stb_o` pulse. In that cycle `shift_dat_o` carries `din_i` as sampled at the edge.
- R6: `standby_o` is 1 when `cs_n_i` is high and `wr_busy_i` is 0. It is 0 while `wr_busy_i` is 1, even with `cs_n_i` high.
- R7: While the slave is selected, `hold_n_i` low with `sclk_i` low sets `held_o` to 1 and forces `dout_en_o` to 0.
- R8: While the slave is not selected, `hold_n_i` has no effect: `held_o` stays 0.
- R9: A change of `hold_n_i` while `sclk_i` is high does not change `held_o`. The change takes effect once `sclk_i` is low again.
- R10: While paused, `hold_n_i` high with `sclk_i` low clears `held_o` and brings `dout_en_o` back to 1.
- R11: While paused, edges on `sclk_i` produce no `shift_stb_o` pulse.
- R12: Raising `cs_n_i` while paused gives exactly one single-cycle `state_clr_o` pulse and clears `held_o`. Raising `cs_n_i` while not paused gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_i | input | 1 | Power-on reset, active high, synchronous to `clk` |
| cs_n_i | input | 1 | Chip select pin, active low |
| sclk_i | input | 1 | Serial clock pin |
| hold_n_i | input | 1 | Pause pin, active low |
| din_i | input | 1 | Serial data-in pin |
| wr_busy_i | input | 1 | Write engine busy, synchronous to `clk` |
| shift_stb_o | output | 1 | One-cycle strobe per qualified serial clock rising edge |
| shift_dat_o | output | 1 | Data bit captured with the strobe |
| dout_en_o | output | 1 | Data output drive enable |
| sel_o | output | 1 | Slave is selected |
| held_o | output | 1 | Serial traffic is paused |
| state_clr_o | output | 1 | One-cycle clear pulse for command and bit-count state |
| standby_o | output | 1 | Slave is idle and may enter low-power standby |

## Verification
The pause release and the deselection can land in the same system clock cycle. In that case the pause logic has to choose between a plain exit from the pause and a deselect clear. The bench provokes this by driving `cs_n_i` high and `hold_n_i` high on the same clock edge while the slave is paused. It then expects exactly one `state_clr_o` pulse, `held_o` at 0 and `standby_o` at 1. The deferred pause change is checked the same way: `hold_n_i` is moved while `sclk_i` is high, and `held_o` must not move until `sclk_i` falls.

// File: rtl/sel_hold_pkg.sv
// Shared types for the select/pause front-end.
// Assumes: pins are sampled as one packed vector through a common synchronizer bank.
package sel_hold_pkg;
    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic hold_n;
        logic din;
    } pin_vec_t;

    localparam int PIN_W = $bits(pin_vec_t);
endpackage

// File: rtl/sync_bank.sv
// Multi-stage synchronizer, one chain per bit.
// Assumes: inputs are quasi-static relative to clk; STAGES >= 2.
module sync_bank #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Purpose: shift the pin level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= {chain_q[STAGES-2:0], d_i[g]};
        end

        assign q_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/select_arm.sv
// Edge-armed selection tracker.
// Selection needs a high-to-low transition of synchronized chip select seen
// outside power-on reset. It is dropped while chip select is high.
// Assumes: the edge-history flop resets low, so a select line that is already
// low at reset release never counts as a fall.
module select_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic por_i,
    input  logic cs_n_s,
    output logic sel_o
);
    logic cs_d_q;
    logic sel_q;
    logic cs_fall;

    assign cs_fall = cs_d_q & ~cs_n_s;

    // Purpose: remember last synchronized chip select level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_d_q <= 1'b0;
        else        cs_d_q <= cs_n_s;
    end

    // Purpose: arm selection on a fall, drop it on high level or power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                sel_q <= 1'b0;
        else if (por_i || cs_n_s)  sel_q <= 1'b0;
        else if (cs_fall)          sel_q <= 1'b1;
    end

    assign sel_o = sel_q;

    // R2: power-on reset keeps the slave deselected
    assert_por_deselects_R2: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> !sel_o);

    // R4: selection never survives a high chip select seen before the edge
    assert_high_cs_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !sel_o);
endmodule

// File: rtl/hold_track.sv
// Pause (hold) state tracker.
// The pause level is followed only while selected and only while the
// synchronized serial clock is low. A change during clock-high waits for the
// next clock-low sample. Deselecting while paused gives a one-cycle clear pulse.
// Assumes: sel_i comes from the selection tracker on the same clock.
module hold_track (
    input  logic clk,
    input  logic rst_n,
    input  logic por_i,
    input  logic sel_i,
    input  logic cs_n_s,
    input  logic sclk_s,
    input  logic hold_n_s,
    output logic held_o,
    output logic clr_o
);
    logic held_q;
    logic clr_q;

    // Purpose: follow the pause level at clock-low samples, clear on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            clr_q <= 1'b0;
            if (por_i) begin
                held_q <= 1'b0;
            end else if (cs_n_s || !sel_i) begin
                clr_q  <= held_q & cs_n_s;
                held_q <= 1'b0;
            end else if (!sclk_s) begin
                held_q <= ~hold_n_s;
            end
        end
    end

    assign held_o = held_q;
    assign clr_o  = clr_q;

    // R8: a pause exists only while the slave is selected
    assert_pause_needs_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        held_o |-> sel_i);

    // R9: the pause state only moves on a clock-low sample
    assert_pause_entry_clk_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held_o) |-> $past(!sclk_s));

    // R12: the clear pulse lasts one cycle
    assert_clear_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> !clr_o);

    // R12: the clear pulse follows a pause that has just ended
    assert_clear_after_pause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> (!held_o && $past(held_o)));
endmodule

// File: rtl/sel_hold_frontend.sv
// Select/pause front-end of a serial memory slave.
// Synchronizes the pins, arms selection on a chip-select fall, tracks the
// pause state and issues one shift strobe per qualified serial clock rise.
// Assumes: clk is several times faster than the serial clock; por_i and
// wr_busy_i are already synchronous to clk.
module sel_hold_frontend
    import sel_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_i,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic hold_n_i,
    input  logic din_i,
    input  logic wr_busy_i,
    output logic shift_stb_o,
    output logic shift_dat_o,
    output logic dout_en_o,
    output logic sel_o,
    output logic held_o,
    output logic state_clr_o,
    output logic standby_o
);
    pin_vec_t pins_raw;
    pin_vec_t pins_s;
    logic     sel;
    logic     held;
    logic     sclk_d_q;
    logic     stb_q;
    logic     dat_q;
    logic     stby_q;
    logic     sclk_rise;

    assign pins_raw = '{cs_n: cs_n_i, sclk: sclk_i, hold_n: hold_n_i, din: din_i};

    sync_bank #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    select_arm i_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .por_i  (por_i),
        .cs_n_s (pins_s.cs_n),
        .sel_o  (sel)
    );

    hold_track i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_i    (por_i),
        .sel_i    (sel),
        .cs_n_s   (pins_s.cs_n),
        .sclk_s   (pins_s.sclk),
        .hold_n_s (pins_s.hold_n),
        .held_o   (held),
        .clr_o    (state_clr_o)
    );

    assign sclk_rise = ~sclk_d_q & pins_s.sclk;

    // Purpose: keep the previous synchronized serial clock for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d_q <= 1'b0;
        else        sclk_d_q <= pins_s.sclk;
    end

    // Purpose: pass a qualified clock rise and its data bit to the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
            dat_q <= 1'b0;
        end else begin
            stb_q <= sclk_rise & sel & ~held & ~pins_s.cs_n & ~por_i;
            if (sclk_rise) dat_q <= pins_s.din;
        end
    end

    // Purpose: report standby when deselected and the write engine is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) stby_q <= 1'b0;
        else        stby_q <= ~por_i & pins_s.cs_n & ~wr_busy_i;
    end

    assign shift_stb_o = stb_q;
    assign shift_dat_o = dat_q;
    assign dout_en_o   = sel & ~held;
    assign sel_o       = sel;
    assign held_o      = held;
    assign standby_o   = stby_q;

    // R11: no strobe is ever issued alongside an active pause
    assert_no_strobe_paused_R11: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb_o |-> !held_o);

    // R5: a strobe lasts a single cycle
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb_o |=> !shift_stb_o);

    // R2: power-on reset blocks strobes
    assert_por_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> !shift_stb_o);

    // R6: standby and selection never coexist
    assert_standby_unselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> !sel_o);
endmodule

// File: tb/test_sel_hold_frontend.sv
`timescale 1ns/1ps
module test_sel_hold_frontend;
    logic clk = 1'b0;
    logic rst_n, por, cs_n, sclk, hold_n, din, busy;
    logic stb, dat, oe, sel, held, clr, stby;

    int n_chk = 0;
    int n_fail = 0;
    int stb_cnt = 0;
    int clr_cnt = 0;
    logic [7:0] cap = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sel_hold_frontend i_sel_hold_frontend (
        .clk(clk), .rst_n(rst_n), .por_i(por), .cs_n_i(cs_n), .sclk_i(sclk),
        .hold_n_i(hold_n), .din_i(din), .wr_busy_i(busy),
        .shift_stb_o(stb), .shift_dat_o(dat), .dout_en_o(oe), .sel_o(sel),
        .held_o(held), .state_clr_o(clr), .standby_o(stby)
    );

    // Pulse monitors, sampled away from the active edge
    always @(negedge clk) begin
        if (stb) begin
            stb_cnt <= stb_cnt + 1;
            cap     <= {cap[6:0], dat};
        end
        if (clr) clr_cnt <= clr_cnt + 1;
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_counts();
        stb_cnt = 0;
        clr_cnt = 0;
    endtask

    task automatic t_reset_and_por();
        rst_n = 0; por = 1; cs_n = 1; sclk = 0; hold_n = 1; din = 0; busy = 0;
        wait_cyc(4);
        rst_n = 1;
        wait_cyc(1);
        check("R1 sel", sel, 0);
        check("R1 held", held, 0);
        check("R1 strobe", stb, 0);
        check("R1 clear", clr, 0);
        check("R1 oe", oe, 0);
        clr_counts();
        wait_cyc(5);
        cs_n = 0; wait_cyc(5);
        for (int i = 0; i < 3; i++) begin
            sclk = 1; wait_cyc(4); sclk = 0; wait_cyc(4);
        end
        cs_n = 1; wait_cyc(5);
        check("R2 standby under por", stby, 0);
        cs_n = 0; wait_cyc(5);
        check("R2 sel under por", sel, 0);
        check("R2 strobes under por", stb_cnt, 0);
    endtask

    task automatic t_arm();
        por = 0; wait_cyc(6);
        check("R3 low cs at release", sel, 0);
        cs_n = 1; wait_cyc(5);
        check("R6 standby idle", stby, 1);
        check("R4 deselected", sel, 0);
        cs_n = 0; wait_cyc(5);
        check("R3 armed by fall", sel, 1);
        check("R4 oe selected", oe, 1);
        check("R6 standby selected", stby, 0);
    endtask

    task automatic t_shift(logic [7:0] pattern);
        clr_counts();
        for (int i = 7; i >= 0; i--) begin
            din = pattern[i]; wait_cyc(4);
            sclk = 1; wait_cyc(4);
            sclk = 0; wait_cyc(4);
        end
        check("R5 strobe count", stb_cnt, 8);
        check("R5 captured byte", cap, pattern);
    endtask

    task automatic t_busy();
        cs_n = 1; busy = 1; wait_cyc(5);
        check("R6 standby busy", stby, 0);
        busy = 0; wait_cyc(5);
        check("R6 standby after busy", stby, 1);
        hold_n = 0; wait_cyc(5);
        check("R8 hold ignored deselected", held, 0);
        hold_n = 1; wait_cyc(2);
        cs_n = 0; wait_cyc(5);
        check("R4 reselected", sel, 1);
    endtask

    task automatic t_hold();
        hold_n = 0; wait_cyc(5);
        check("R7 held", held, 1);
        check("R7 oe off", oe, 0);
        clr_counts();
        for (int i = 0; i < 3; i++) begin
            sclk = 1; wait_cyc(4); sclk = 0; wait_cyc(4);
        end
        check("R11 no strobes held", stb_cnt, 0);
        sclk = 1; wait_cyc(4);
        hold_n = 1; wait_cyc(5);
        check("R9 exit deferred", held, 1);
        sclk = 0; wait_cyc(5);
        check("R10 exit", held, 0);
        check("R10 oe back", oe, 1);
        sclk = 1; wait_cyc(4);
        hold_n = 0; wait_cyc(5);
        check("R9 entry deferred", held, 0);
        sclk = 0; wait_cyc(5);
        check("R9 entry at clock low", held, 1);
        hold_n = 1; wait_cyc(5);
        check("R10 exit again", held, 0);
    endtask

    task automatic t_deselect();
        clr_counts();
        cs_n = 1; wait_cyc(5);
        check("R12 no clear unpaused", clr_cnt, 0);
        cs_n = 0; wait_cyc(5);
        hold_n = 0; wait_cyc(5);
        clr_counts();
        cs_n = 1; wait_cyc(5);
        check("R12 clear pulse", clr_cnt, 1);
        check("R12 held cleared", held, 0);
        check("R4 sel dropped", sel, 0);
        hold_n = 1; wait_cyc(3);
    endtask

    task automatic t_concurrent();
        cs_n = 0; wait_cyc(5);
        hold_n = 0; wait_cyc(5);
        check("R7 held before race", held, 1);
        clr_counts();
        cs_n = 1; hold_n = 1; wait_cyc(6);
        check("R12 clear on joint release", clr_cnt, 1);
        check("R12 held after joint release", held, 0);
        check("R6 standby after joint release", stby, 1);
    endtask

    initial begin
        t_reset_and_por();
        t_arm();
        t_shift(8'hA5);
        t_shift(8'h3C);
        t_busy();
        t_hold();
        t_deselect();
        t_concurrent();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule